// File: doc/BRIEF.md
# Vector Shader Register File with Indexed Operand Addressing

This block holds the register state of a small vertex-shader style processor. Every register is a 128-bit vector of four 32-bit lanes, which the block treats as opaque bit patterns. A 7-bit operand identifier is decoded into one of four separate banks: input attributes, outputs, temporaries and uniforms. The decode differs between the read and write paths, so the same identifier can reach different storage depending on the direction.

The shader side has two combinational read ports and one clocked write port. The first read port takes a 7-bit identifier and a 2-bit selector. The selector picks an offset that is added to the identifier before it is decoded: none, one of two index registers, or the loop counter. The second read port takes a 5-bit identifier, so it reaches only the attribute and temporary banks.

A host-side port loads the attribute and uniform banks. A separate host read port returns the output registers once the shader has finished.

Top module: `vsh_regfile`

## Requirements
- R1: Reset clears every register in all four banks and clears both index registers and the loop counter, so every read port returns zero after reset.
- R2: With selector 0, the first read port decodes identifier 0x00–0x0F to the attribute bank, 0x10–0x1F to the temporary bank and 0x20–0x7F to uniform row (id − 0x20).
- R3: A shader write with identifier 0x00–0x0F stores into output register id. A write with 0x10–0x1F stores into temporary register (id − 0x10). A write with 0x20–0x7F is ignored.
- R4: A shader write and a read that use the same identifier in 0x00–0x0F touch different storage: writing 0x05 never changes what a read of 0x05 returns.
- R5: The second read port decodes its 5-bit identifier with bit 4 clear to the attribute bank and with bit 4 set to the temporary bank. It returns the same data as the first port for that identifier with selector 0.
- R6: The first port's offset selector encodes 0 = no offset, 1 = index register A, 2 = index register B, 3 = loop counter. The effective identifier is (id + offset) mod 128, for example 0x28 + 3 = 0x2B and 0x7E + 5 = 0x03.
- R7: The set-index strobe loads both index registers on a rising edge. The loop strobe loads the loop counter on a rising edge. Each keeps its value until it is loaded again.
- R8: Reads are combinational from the stored state. A write takes effect at the rising edge, so a read in the same cycle as a write to that register returns the old value.
- R9: A host load with address 0x00–0x0F writes that attribute register, and one with 0x20–0x7F writes uniform row (addr − 0x20). A host load with address 0x10–0x1F is ignored.
- R10: The host output read port returns, combinationally, the output register selected by its 4-bit index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| src1_id | input | 7 | First read identifier |
| src1_ofs_sel | input | 2 | Offset selector for the first read |
| src1_data | output | 128 | First read data |
| src2_id | input | 5 | Second read identifier |
| src2_data | output | 128 | Second read data |
| dst_we | input | 1 | Shader write strobe |
| dst_id | input | 7 | Shader write identifier |
| dst_data | input | 128 | Shader write data |
| ofs_set_we | input | 1 | Loads both index registers |
| ofs_a_val | input | 7 | New value of index register A |
| ofs_b_val | input | 7 | New value of index register B |
| loop_we | input | 1 | Loads the loop counter |
| loop_val | input | 7 | New loop counter value |
| host_we | input | 1 | Host load strobe |
| host_addr | input | 7 | Host load address (read-side numbering) |
| host_wdata | input | 128 | Host load data |
| host_out_sel | input | 4 | Output register to read back |
| host_out_data | output | 128 | Selected output register |

## Verification
On every cycle, the assertions check the following:
- A temporary write is seen on the next cycle through the second port.
- An output write appears on the host read-back port.
- A host attribute load is visible through the second port.
- A shader write aimed at the uniform range leaves the uniform data unchanged.
- The two read ports agree on any identifier they share when no offset is applied.

Only the bench's scenarios can show the remaining behaviour:
- the offset arithmetic and its wrap at 128;
- the retention of the index and loop registers;
- the separation of reads and writes that share the same low identifiers;
- the ignored host load into the temporary range;
- the same-cycle read of the old value.

// File: rtl/vsh_pkg.sv
package vsh_pkg;
    localparam int LANES     = 4;
    localparam int LANE_W    = 32;
    localparam int VEC_W     = LANES * LANE_W;
    localparam int ID_W      = 7;
    localparam int ID2_W     = 5;
    localparam int SEL_W     = 2;
    localparam int N_ATTR    = 16;
    localparam int N_OUT     = 16;
    localparam int N_TEMP    = 16;
    localparam int TEMP_BASE = 16;
    localparam int UNIF_BASE = 32;
    localparam int N_UNIF    = (1 << ID_W) - UNIF_BASE;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [ID_W-1:0]  id_t;

    typedef enum logic [1:0] {RB_NONE, RB_ATTR, RB_TEMP, RB_UNIF} rd_bank_e;
    typedef enum logic [1:0] {WB_NONE, WB_OUT, WB_TEMP} wr_bank_e;

    typedef struct packed {
        rd_bank_e bank;
        id_t      row;
    } rd_route_t;

    typedef struct packed {
        wr_bank_e bank;
        id_t      row;
    } wr_route_t;

    function automatic rd_route_t route_read(input id_t id);
        rd_route_t r;
        r.bank = RB_NONE;
        r.row  = '0;
        if (int'(id) < N_ATTR) begin
            r.bank = RB_ATTR;
            r.row  = id;
        end else if (int'(id) < TEMP_BASE + N_TEMP) begin
            r.bank = RB_TEMP;
            r.row  = id - id_t'(TEMP_BASE);
        end else if (int'(id) >= UNIF_BASE && int'(id) < UNIF_BASE + N_UNIF) begin
            r.bank = RB_UNIF;
            r.row  = id - id_t'(UNIF_BASE);
        end
        return r;
    endfunction

    function automatic wr_route_t route_write(input id_t id);
        wr_route_t w;
        w.bank = WB_NONE;
        w.row  = '0;
        if (int'(id) < N_OUT) begin
            w.bank = WB_OUT;
            w.row  = id;
        end else if (int'(id) >= TEMP_BASE && int'(id) < TEMP_BASE + N_TEMP) begin
            w.bank = WB_TEMP;
            w.row  = id - id_t'(TEMP_BASE);
        end
        return w;
    endfunction
endpackage

// File: rtl/vsh_vec_bank.sv
module vsh_vec_bank #(
    parameter int DEPTH = 16,
    parameter int W     = 128,
    parameter int N_RD  = 1,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [W-1:0]             wdata,
    input  logic [N_RD-1:0][AW-1:0]  raddr,
    output logic [N_RD-1:0][W-1:0]   rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && int'(waddr) < DEPTH) begin
            st_d.mem[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        always_comb begin
            rdata[p] = '0;
            if (int'(raddr[p]) < DEPTH) rdata[p] = st_q.mem[raddr[p]];
        end
    end
endmodule

// File: rtl/vsh_index_unit.sv
module vsh_index_unit #(
    parameter int OW    = 7,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic [OW-1:0]    set_a,
    input  logic [OW-1:0]    set_b,
    input  logic             loop_we,
    input  logic [OW-1:0]    loop_val,
    input  logic [SEL_W-1:0] sel,
    output logic [OW-1:0]    offset
);
    typedef struct packed {
        logic [OW-1:0] a;
        logic [OW-1:0] b;
        logic [OW-1:0] lc;
    } idx_st_t;

    idx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) begin
            st_d.a = set_a;
            st_d.b = set_b;
        end
        if (loop_we) st_d.lc = loop_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (sel)
            2'd1:    offset = st_q.a;
            2'd2:    offset = st_q.b;
            2'd3:    offset = st_q.lc;
            default: offset = '0;
        endcase
    end
endmodule

// File: rtl/vsh_regfile.sv
module vsh_regfile
    import vsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   src1_id,
    input  logic [SEL_W-1:0]  src1_ofs_sel,
    output logic [VEC_W-1:0]  src1_data,
    input  logic [ID2_W-1:0]  src2_id,
    output logic [VEC_W-1:0]  src2_data,
    input  logic              dst_we,
    input  logic [ID_W-1:0]   dst_id,
    input  logic [VEC_W-1:0]  dst_data,
    input  logic              ofs_set_we,
    input  logic [ID_W-1:0]   ofs_a_val,
    input  logic [ID_W-1:0]   ofs_b_val,
    input  logic              loop_we,
    input  logic [ID_W-1:0]   loop_val,
    input  logic              host_we,
    input  logic [ID_W-1:0]   host_addr,
    input  logic [VEC_W-1:0]  host_wdata,
    input  logic [3:0]        host_out_sel,
    output logic [VEC_W-1:0]  host_out_data
);
    localparam int AW_ATTR = $clog2(N_ATTR);
    localparam int AW_OUT  = $clog2(N_OUT);
    localparam int AW_TEMP = $clog2(N_TEMP);
    localparam int AW_UNIF = $clog2(N_UNIF);

    // effective first-port identifier
    logic [ID_W-1:0] ofs;
    id_t             eff_id;
    rd_route_t       r1, r2;
    wr_route_t       wr, hr;

    vsh_index_unit #(.OW(ID_W), .SEL_W(SEL_W)) i_idx (
        .clk(clk), .rst_n(rst_n),
        .set_we(ofs_set_we), .set_a(ofs_a_val), .set_b(ofs_b_val),
        .loop_we(loop_we), .loop_val(loop_val),
        .sel(src1_ofs_sel), .offset(ofs)
    );

    always_comb begin
        eff_id = src1_id + ofs;
        r1     = route_read(eff_id);
        r2     = route_read(id_t'(src2_id));
        wr     = route_write(dst_id);
        hr     = route_read(host_addr);
    end

    // attribute bank: host writes, two shader reads
    logic [1:0][AW_ATTR-1:0] attr_ra;
    logic [1:0][VEC_W-1:0]   attr_rd;
    logic                    attr_we;
    // temporary bank: shader writes, two shader reads
    logic [1:0][AW_TEMP-1:0] temp_ra;
    logic [1:0][VEC_W-1:0]   temp_rd;
    logic                    temp_we;
    // uniform bank: host writes, first-port reads
    logic [0:0][AW_UNIF-1:0] unif_ra;
    logic [0:0][VEC_W-1:0]   unif_rd;
    logic                    unif_we;
    // output bank: shader writes, host read-back
    logic [0:0][AW_OUT-1:0]  out_ra;
    logic [0:0][VEC_W-1:0]   out_rd;
    logic                    out_we;

    always_comb begin
        attr_we    = host_we && (hr.bank == RB_ATTR);
        unif_we    = host_we && (hr.bank == RB_UNIF);
        temp_we    = dst_we  && (wr.bank == WB_TEMP);
        out_we     = dst_we  && (wr.bank == WB_OUT);
        attr_ra[0] = r1.row[AW_ATTR-1:0];
        attr_ra[1] = r2.row[AW_ATTR-1:0];
        temp_ra[0] = r1.row[AW_TEMP-1:0];
        temp_ra[1] = r2.row[AW_TEMP-1:0];
        unif_ra[0] = r1.row[AW_UNIF-1:0];
        out_ra[0]  = host_out_sel[AW_OUT-1:0];
    end

    vsh_vec_bank #(.DEPTH(N_ATTR), .W(VEC_W), .N_RD(2)) i_attr (
        .clk(clk), .rst_n(rst_n), .we(attr_we), .waddr(hr.row[AW_ATTR-1:0]),
        .wdata(host_wdata), .raddr(attr_ra), .rdata(attr_rd)
    );

    vsh_vec_bank #(.DEPTH(N_TEMP), .W(VEC_W), .N_RD(2)) i_temp (
        .clk(clk), .rst_n(rst_n), .we(temp_we), .waddr(wr.row[AW_TEMP-1:0]),
        .wdata(dst_data), .raddr(temp_ra), .rdata(temp_rd)
    );

    vsh_vec_bank #(.DEPTH(N_UNIF), .W(VEC_W), .N_RD(1)) i_unif (
        .clk(clk), .rst_n(rst_n), .we(unif_we), .waddr(hr.row[AW_UNIF-1:0]),
        .wdata(host_wdata), .raddr(unif_ra), .rdata(unif_rd)
    );

    vsh_vec_bank #(.DEPTH(N_OUT), .W(VEC_W), .N_RD(1)) i_out (
        .clk(clk), .rst_n(rst_n), .we(out_we), .waddr(wr.row[AW_OUT-1:0]),
        .wdata(dst_data), .raddr(out_ra), .rdata(out_rd)
    );

    always_comb begin
        unique case (r1.bank)
            RB_ATTR: src1_data = attr_rd[0];
            RB_TEMP: src1_data = temp_rd[0];
            RB_UNIF: src1_data = unif_rd[0];
            default: src1_data = '0;
        endcase
        unique case (r2.bank)
            RB_ATTR: src2_data = attr_rd[1];
            RB_TEMP: src2_data = temp_rd[1];
            default: src2_data = '0;
        endcase
        host_out_data = out_rd[0];
    end
endmodule

// File: rtl/vsh_regfile_chk.sv
module vsh_regfile_chk
    import vsh_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ID_W-1:0]   src1_id,
    input logic [SEL_W-1:0]  src1_ofs_sel,
    input logic [VEC_W-1:0]  src1_data,
    input logic [ID2_W-1:0]  src2_id,
    input logic [VEC_W-1:0]  src2_data,
    input logic              dst_we,
    input logic [ID_W-1:0]   dst_id,
    input logic [VEC_W-1:0]  dst_data,
    input logic              host_we,
    input logic [ID_W-1:0]   host_addr,
    input logic [VEC_W-1:0]  host_wdata,
    input logic [3:0]        host_out_sel,
    input logic [VEC_W-1:0]  host_out_data
);
    // temporary write visible next cycle through second port
    assert_temp_wr_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && dst_id[6:4] == 3'b001) |=>
        (src2_id != $past(dst_id[4:0]) || src2_data == $past(dst_data)));

    // output write visible on host read-back
    assert_out_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && dst_id[6:4] == 3'b000) |=>
        (host_out_sel != $past(dst_id[3:0]) || host_out_data == $past(dst_data)));

    // host attribute load visible through second port
    assert_attr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr[6:4] == 3'b000) |=>
        (src2_id != {1'b0, $past(host_addr[3:0])} || src2_data == $past(host_wdata)));

    // shader write into uniform range leaves uniform data intact
    assert_unif_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && dst_id[6:5] != 2'b00 && !host_we &&
         src1_ofs_sel == 2'd0 && src1_id == dst_id) |=>
        (src1_ofs_sel != 2'd0 || src1_id != $past(src1_id) || $stable(src1_data)));

    // both read ports agree on shared identifiers without offset
    assert_port_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src1_ofs_sel == 2'd0 && src1_id[6:5] == 2'b00 && src2_id == src1_id[4:0]) |->
        (src1_data == src2_data));
endmodule

bind vsh_regfile vsh_regfile_chk i_chk (
    .clk(clk), .rst_n(rst_n), .src1_id(src1_id), .src1_ofs_sel(src1_ofs_sel),
    .src1_data(src1_data), .src2_id(src2_id), .src2_data(src2_data),
    .dst_we(dst_we), .dst_id(dst_id), .dst_data(dst_data),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_out_sel(host_out_sel), .host_out_data(host_out_data)
);

// File: tb/test_vsh_regfile.sv
`timescale 1ns/1ps
module test_vsh_regfile;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [6:0]   src1_id = '0;
    logic [1:0]   src1_ofs_sel = '0;
    logic [127:0] src1_data;
    logic [4:0]   src2_id = '0;
    logic [127:0] src2_data;
    logic         dst_we = 1'b0;
    logic [6:0]   dst_id = '0;
    logic [127:0] dst_data = '0;
    logic         ofs_set_we = 1'b0;
    logic [6:0]   ofs_a_val = '0;
    logic [6:0]   ofs_b_val = '0;
    logic         loop_we = 1'b0;
    logic [6:0]   loop_val = '0;
    logic         host_we = 1'b0;
    logic [6:0]   host_addr = '0;
    logic [127:0] host_wdata = '0;
    logic [3:0]   host_out_sel = '0;
    logic [127:0] host_out_data;

    int total = 0;
    int bad = 0;

    // reference state
    logic [127:0] m_attr [16];
    logic [127:0] m_out  [16];
    logic [127:0] m_temp [16];
    logic [127:0] m_unif [96];
    logic [6:0]   m_a, m_b, m_lc;

    always #10 clk = ~clk;

    vsh_regfile i_vsh_regfile (.*);

    function automatic logic [127:0] rnd_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [127:0] exp_read(input logic [6:0] id);
        if (id < 7'd16)      return m_attr[id[3:0]];
        else if (id < 7'd32) return m_temp[id[3:0]];
        else                 return m_unif[int'(id) - 32];
    endfunction

    function automatic logic [127:0] exp_src1(input logic [6:0] id, input logic [1:0] sel);
        logic [6:0] o;
        case (sel)
            2'd1:    o = m_a;
            2'd2:    o = m_b;
            2'd3:    o = m_lc;
            default: o = 7'd0;
        endcase
        return exp_read(id + o);
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        dst_we = 1'b0; ofs_set_we = 1'b0; loop_we = 1'b0; host_we = 1'b0;
    endtask

    // advance one edge, updating the reference with the applied inputs
    task automatic tick();
        @(posedge clk);
        if (host_we) begin
            if (host_addr < 7'd16)       m_attr[host_addr[3:0]] = host_wdata;
            else if (host_addr >= 7'd32) m_unif[int'(host_addr) - 32] = host_wdata;
        end
        if (dst_we) begin
            if (dst_id < 7'd16)      m_out[dst_id[3:0]] = dst_data;
            else if (dst_id < 7'd32) m_temp[dst_id[3:0]] = dst_data;
        end
        if (ofs_set_we) begin m_a = ofs_a_val; m_b = ofs_b_val; end
        if (loop_we) m_lc = loop_val;
        @(negedge clk);
        quiet();
    endtask

    logic [127:0] v_u, v_w, v_x, v_y;

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_2468));
        for (int i = 0; i < 16; i++) begin m_attr[i] = '0; m_out[i] = '0; m_temp[i] = '0; end
        for (int i = 0; i < 96; i++) m_unif[i] = '0;
        m_a = '0; m_b = '0; m_lc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything reads zero after reset
        src1_id = 7'h40; src2_id = 5'h13; host_out_sel = 4'd7; #1;
        chk("R1 src1 after reset", src1_data, '0);
        chk("R1 src2 after reset", src2_data, '0);
        chk("R1 host out after reset", host_out_data, '0);

        // R6/R9: offset example 0x28 + idxB(3) = 0x2B
        v_u = rnd_vec();
        host_we = 1'b1; host_addr = 7'h2B; host_wdata = v_u;
        ofs_set_we = 1'b1; ofs_a_val = 7'd1; ofs_b_val = 7'd3;
        tick();
        src1_id = 7'h28; src1_ofs_sel = 2'd2; #1;
        chk("R6 idxB offset 0x28+3", src1_data, v_u);
        src1_ofs_sel = 2'd1; #1;
        chk("R6 idxA offset 0x28+1", src1_data, '0);
        src1_id = 7'h2B; src1_ofs_sel = 2'd0; #1;
        chk("R9 host uniform load", src1_data, v_u);

        // R6: wrap with loop counter 0x7E + 5 = 0x03
        v_w = rnd_vec();
        loop_we = 1'b1; loop_val = 7'd5;
        host_we = 1'b1; host_addr = 7'h03; host_wdata = v_w;
        tick();
        src1_id = 7'h7E; src1_ofs_sel = 2'd3; #1;
        chk("R6 loop wrap 0x7E+5", src1_data, v_w);

        // R7: loop counter retained when index registers reload
        ofs_set_we = 1'b1; ofs_a_val = 7'd9; ofs_b_val = 7'd10;
        tick();
        tick();
        #1;
        chk("R7 loop counter retained", src1_data, v_w);
        src1_id = 7'h10; src1_ofs_sel = 2'd1; #1;
        chk("R7 idxA reloaded", src1_data, '0);

        // R8/R3/R4: output write vs attribute read at 0x03
        v_x = rnd_vec();
        dst_we = 1'b1; dst_id = 7'h03; dst_data = v_x;
        host_out_sel = 4'd3; src1_id = 7'h03; src1_ofs_sel = 2'd0; #1;
        chk("R8 same-cycle host out old", host_out_data, '0);
        tick();
        #1;
        chk("R3 output write", host_out_data, v_x);
        chk("R4 read 0x03 still attribute", src1_data, v_w);
        src2_id = 5'h03; #1;
        chk("R4 src2 0x03 still attribute", src2_data, v_w);

        // R3/R8: temporary write and same-cycle read
        v_y = rnd_vec();
        dst_we = 1'b1; dst_id = 7'h11; dst_data = v_y; src2_id = 5'h11; #1;
        chk("R8 same-cycle temp old", src2_data, '0);
        tick();
        src1_id = 7'h11; #1;
        chk("R3 temp write via src2", src2_data, v_y);
        chk("R3 temp write via src1", src1_data, v_y);

        // R3: shader write to uniform ignored
        dst_we = 1'b1; dst_id = 7'h2B; dst_data = rnd_vec();
        tick();
        src1_id = 7'h2B; #1;
        chk("R3 uniform write ignored", src1_data, v_u);

        // R9: host load into temporary range ignored
        host_we = 1'b1; host_addr = 7'h12; host_wdata = rnd_vec();
        tick();
        src2_id = 5'h12; #1;
        chk("R9 host temp load ignored", src2_data, '0);

        // random phase: R2, R5, R6, R10 against reference
        for (int n = 0; n < 3000; n++) begin
            dst_we     = ($urandom_range(0, 2) == 0);
            dst_id     = 7'($urandom_range(0, 127));
            dst_data   = rnd_vec();
            host_we    = ($urandom_range(0, 2) == 0);
            host_addr  = 7'($urandom_range(0, 127));
            host_wdata = rnd_vec();
            ofs_set_we = ($urandom_range(0, 15) == 0);
            ofs_a_val  = 7'($urandom_range(0, 127));
            ofs_b_val  = 7'($urandom_range(0, 127));
            loop_we    = ($urandom_range(0, 15) == 0);
            loop_val   = 7'($urandom_range(0, 127));
            src1_id    = 7'($urandom_range(0, 127));
            src1_ofs_sel = 2'($urandom_range(0, 3));
            src2_id    = 5'($urandom_range(0, 31));
            host_out_sel = 4'($urandom_range(0, 15));
            #1;
            if (src1_ofs_sel == 2'd0)
                chk("R2 src1 decode", src1_data, exp_src1(src1_id, src1_ofs_sel));
            else
                chk("R6 src1 offset", src1_data, exp_src1(src1_id, src1_ofs_sel));
            chk("R5 src2 decode", src2_data, exp_read({2'b00, src2_id}));
            chk("R10 host out", host_out_data, m_out[host_out_sel]);
            tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule